// File: doc/BRIEF.md
# Byte-Wide Master Configuration Loader

This block pulls a configuration image out of an external byte-wide memory and forwards it as a serial stream to downstream devices that are chained behind it. A start strobe, qualified by a three-bit mode code, begins a load. The block then drives an address that counts up from zero or down from the top of the address space. It captures one byte per read-clock period and shifts that byte out least significant bit first. A configuration clock that runs at eight times the read-clock rate accompanies the serial stream.

The system clock generates both outgoing clocks through one divider, so one read-clock period always spans exactly eight configuration-clock periods. The next address is presented while the current byte is still shifting, so the memory has a full byte period of access time and the serial stream has no gaps between bytes. A parameterized byte count ends the load.

Top module: `cfg_byte_loader`

## Requirements
- R1: While reset is low, and after it is released, busy is 0, mem_addr is 0, cclk is 1, rclk is 0 and dout is 1.
- R2: With mode_sel = 3'b100, a start pulse while idle begins a load whose first address is 0, and the address increases by exactly 1 for each later byte.
- R3: With mode_sel = 3'b110, a start pulse while idle begins a load whose first address is 18'h3FFFF, and the address decreases by exactly 1 for each later byte.
- R4: For every other mode_sel code a start pulse is ignored: busy stays 0 and mem_addr keeps its value.
- R5: While busy, cclk is low for HALF_DIV system cycles and then high for HALF_DIV cycles. rclk is high during the first four cclk periods of each byte and low during the last four, so one rclk period is eight cclk periods, and each rclk rising edge falls on a cclk falling edge.
- R6: The byte that is captured on each rclk rising edge is the memory data at the address that was driven before that edge. The address moves to the next byte directly after the capture.
- R7: Each byte is sent on dout least significant bit first, one bit per cclk period. dout changes only when cclk falls, and the bits of consecutive bytes follow one another without a gap.
- R8: After a start is accepted there is one lead-in cclk period (low, then high) before the first capture. During it busy is 1, rclk is 0, dout is 1 and mem_addr holds the first address.
- R9: After NUM_BYTES bytes busy drops at the end of the last bit's cclk period. mem_addr then holds the address of the last byte, cclk stays 1, rclk stays 0 and dout holds the last bit sent.
- R10: While busy, start pulses and changes of mode_sel have no effect on the load in progress.
- R11: Asserting reset during a load aborts it immediately and returns the outputs to the state given in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode code: 3'b100 counts up, 3'b110 counts down |
| start | input | 1 | Start strobe, sampled on the rising clock edge |
| mem_data | input | DATA_W | Byte read from the external memory |
| mem_addr | output | ADDR_W | Address driven to the external memory |
| rclk | output | 1 | Read clock; a byte is captured on its rising edge |
| cclk | output | 1 | Configuration clock, eight times the read-clock rate |
| dout | output | 1 | Serial data to downstream devices, LSB first |
| busy | output | 1 | High while a load is in progress |

## Verification
Every output comes from a register. With k counting the rising edges from the edge that accepts the start, the output sampled after edge k maps to a position in a timeline of half-periods. The lead-in occupies the last two half-periods of a phantom byte. Byte b then covers half-periods 16·(b+1) onward, and busy drops when byte NUM_BYTES would begin. The bench samples at the falling system-clock edge. It derives busy, both clocks, dout and the expected address from k alone, so every result is compared in the exact cycle it is due and never in a window.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   localparam logic [2:0] MODE_MASTER_UP   = 3'b100;
   localparam logic [2:0] MODE_MASTER_DOWN = 3'b110;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DOWN = 2'd2
   } cfgld_dir_e;

   function automatic cfgld_dir_e decode_mode(input logic [2:0] code);
      cfgld_dir_e d;
      case (code)
         MODE_MASTER_UP:   d = DIR_UP;
         MODE_MASTER_DOWN: d = DIR_DOWN;
         default:          d = DIR_NONE;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/cfgld_timebase.sv
module cfgld_timebase #(
   parameter int unsigned HALF_DIV = 2,
   parameter int unsigned BITS     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic stop,
   output logic byte_end,
   output logic bit_end,
   output logic cclk,
   output logic rclk
);

   localparam int unsigned HALVES = 2 * BITS;
   localparam int unsigned HW     = $clog2(HALVES);
   localparam int unsigned SW     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [HW-1:0] H_LAST = HW'(HALVES - 1);
   localparam logic [HW-1:0] H_LEAD = HW'(HALVES - 2);
   localparam logic [SW-1:0] S_LAST = SW'(HALF_DIV - 1);

   if (HALF_DIV < 1) begin : g_chk_div
      $error("cfgld_timebase: HALF_DIV must be at least 1");
   end
   if ((BITS < 2) || ((BITS & (BITS - 1)) != 0)) begin : g_chk_bits
      $error("cfgld_timebase: BITS must be a power of two, at least 2");
   end

   logic [SW-1:0] sub_q;
   logic [HW-1:0] half_q;
   logic          active_q;
   logic          half_end;

   assign half_end = active_q && (sub_q == S_LAST);
   assign byte_end = half_end && (half_q == H_LAST);
   assign bit_end  = half_end && half_q[0] && (half_q != H_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q    <= '0;
         half_q   <= H_LAST;
         active_q <= 1'b0;
      end else if (restart) begin
         sub_q    <= '0;
         half_q   <= H_LEAD;
         active_q <= 1'b1;
      end else if (stop) begin
         sub_q    <= '0;
         half_q   <= H_LAST;
         active_q <= 1'b0;
      end else if (half_end) begin
         sub_q    <= '0;
         half_q   <= half_q + 1'b1;
      end else if (active_q) begin
         sub_q    <= sub_q + 1'b1;
      end
   end

   assign cclk = half_q[0];
   assign rclk = (half_q < HW'(BITS));

   AST_RCLK_ON_CCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rclk) |-> $fell(cclk)); // R5

   AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> (cclk && !rclk)); // R9

endmodule

// File: rtl/cfgld_addr_gen.sv
module cfgld_addr_gen #(
   parameter int unsigned ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              count_down,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);

   if (ADDR_W < 1) begin : g_chk_w
      $error("cfgld_addr_gen: ADDR_W must be at least 1");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              down_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         down_q <= 1'b0;
      end else if (restart) begin
         addr_q <= count_down ? {ADDR_W{1'b1}} : '0;
         down_q <= count_down;
      end else if (step) begin
         addr_q <= down_q ? (addr_q - 1'b1) : (addr_q + 1'b1);
      end
   end

   assign addr = addr_q;

endmodule

// File: rtl/cfgld_serializer.sv
module cfgld_serializer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] data_in,
   output logic         sdo
);

   if (W < 2) begin : g_chk_w
      $error("cfgld_serializer: W must be at least 2");
   end

   logic [W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '1;
      end else if (restart) begin
         sh_q <= '1;
      end else if (load) begin
         sh_q <= data_in;
      end else if (shift) begin
         sh_q <= {1'b1, sh_q[W-1:1]};
      end
   end

   assign sdo = sh_q[0];

   AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift)); // R7

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned HALF_DIV  = 2,
   parameter int unsigned NUM_BYTES = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_sel,
   input  logic              start,
   input  logic [DATA_W-1:0] mem_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              rclk,
   output logic              cclk,
   output logic              dout,
   output logic              busy
);

   import cfgld_pkg::*;

   localparam int unsigned BCW = $clog2(NUM_BYTES + 1);
   localparam logic [BCW-1:0] B_LAST = BCW'(NUM_BYTES - 1);
   localparam logic [BCW-1:0] B_DONE = BCW'(NUM_BYTES);

   if (NUM_BYTES < 1) begin : g_chk_n
      $error("cfg_byte_loader: NUM_BYTES must be at least 1");
   end
   if (64'(NUM_BYTES) > (64'd1 << ADDR_W)) begin : g_chk_span
      $error("cfg_byte_loader: NUM_BYTES exceeds the address space");
   end

   cfgld_dir_e     dir_sel;
   logic           accept;
   logic           busy_q;
   logic [BCW-1:0] bcnt_q;
   logic           byte_end;
   logic           bit_end;
   logic           finish;
   logic           load;
   logic           step;

   assign dir_sel = decode_mode(mode_sel);
   assign accept  = start && !busy_q && (dir_sel != DIR_NONE);
   assign finish  = byte_end && (bcnt_q == B_DONE);
   assign load    = byte_end && !finish;
   assign step    = load && (bcnt_q != B_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         bcnt_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         bcnt_q <= '0;
      end else begin
         if (finish) busy_q <= 1'b0;
         if (load)   bcnt_q <= bcnt_q + 1'b1;
      end
   end

   cfgld_timebase #(
      .HALF_DIV (HALF_DIV),
      .BITS     (DATA_W)
   ) u_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (accept),
      .stop     (finish),
      .byte_end (byte_end),
      .bit_end  (bit_end),
      .cclk     (cclk),
      .rclk     (rclk)
   );

   cfgld_addr_gen #(
      .ADDR_W     (ADDR_W)
   ) u_addr_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (accept),
      .count_down (dir_sel == DIR_DOWN),
      .step       (step),
      .addr       (mem_addr)
   );

   cfgld_serializer #(
      .W       (DATA_W)
   ) u_serializer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .load    (load),
      .shift   (bit_end && busy_q),
      .data_in (mem_data),
      .sdo     (dout)
   );

   assign busy = busy_q;

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start)); // R4

   AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !accept) |=> $stable(mem_addr)); // R9

   AST_ADDR_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |->
         ((mem_addr == $past(mem_addr)) ||
          (mem_addr == $past(mem_addr) + 1'b1) ||
          (mem_addr == $past(mem_addr) - 1'b1))); // R2

   AST_DOUT_ON_CCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> $fell(cclk)); // R7

   AST_BCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt_q <= B_DONE); // R9

endmodule

// File: tb/cfg_byte_loader_bench.sv
module cfg_byte_loader_bench;

   localparam int AW     = 18;
   localparam int DW     = 8;
   localparam int LHALF  = 2;
   localparam int LN     = 3;
   localparam int HALVES = 2 * DW;
   localparam int BYTE_C = HALVES * LHALF;
   localparam int LOAD_K = BYTE_C * LN + 2 * LHALF;

   // table entry: {mode_sel[2:0], starts_load, counts_down}
   localparam logic [4:0] VEC [0:7] = '{
      {3'b000, 1'b0, 1'b0},
      {3'b100, 1'b1, 1'b0},
      {3'b001, 1'b0, 1'b0},
      {3'b110, 1'b1, 1'b1},
      {3'b010, 1'b0, 1'b0},
      {3'b011, 1'b0, 1'b0},
      {3'b101, 1'b0, 1'b0},
      {3'b111, 1'b0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode_sel = 3'b000;
   logic          start = 1'b0;
   logic [DW-1:0] mem_data;
   logic [AW-1:0] mem_addr;
   logic          rclk, cclk, dout, busy;

   int checks = 0;
   int errors = 0;
   logic [AW-1:0] cur_addr = '0;

   always #4 clk = ~clk;

   function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
      logic [DW-1:0] t;
      t = a[7:0] * 8'd3;
      return (t + {a[13:8], a[17:16]}) ^ 8'hA5;
   endfunction

   assign mem_data = mem_f(mem_addr);

   cfg_byte_loader #(
      .ADDR_W    (AW),
      .DATA_W    (DW),
      .HALF_DIV  (LHALF),
      .NUM_BYTES (LN)
   ) u_cfg_byte_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .start    (start),
      .mem_data (mem_data),
      .mem_addr (mem_addr),
      .rclk     (rclk),
      .cclk     (cclk),
      .dout     (dout),
      .busy     (busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] offs(input logic [AW-1:0] base, input bit down, input int n);
      return down ? base - AW'(n) : base + AW'(n);
   endfunction

   // expected {busy, cclk, rclk, dout, addr} for the sample after edge k
   function automatic logic [AW+3:0] expect_at(input int k, input bit down);
      logic [AW-1:0] base;
      int j, m, h;
      logic b, c, r, d;
      logic [AW-1:0] a;
      base = down ? {AW{1'b1}} : '0;
      j = k + (HALVES - 2) * LHALF;
      m = j / BYTE_C;
      h = (j / LHALF) % HALVES;
      if (m >= LN + 1) begin
         b = 1'b0; c = 1'b1; r = 1'b0;
         d = mem_f(offs(base, down, LN - 1))[DW-1];
         a = offs(base, down, LN - 1);
      end else begin
         b = 1'b1;
         c = h[0];
         r = (h < DW);
         d = (m == 0) ? 1'b1 : mem_f(offs(base, down, m - 1))[h / 2];
         a = offs(base, down, (m < LN - 1) ? m : LN - 1);
      end
      return {b, c, r, d, a};
   endfunction

   task automatic run_load(input logic [2:0] mode, input bit down, input bit disturb);
      logic [AW+3:0] e;
      @(negedge clk);
      mode_sel = mode;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k <= LOAD_K + 3; k++) begin
         e = expect_at(k, down);
         check(k < 2 * LHALF ? "R8 busy" : "R9 busy", 32'(busy), 32'(e[AW+3]));
         check("R5 cclk", 32'(cclk), 32'(e[AW+2]));
         check("R5 rclk", 32'(rclk), 32'(e[AW+1]));
         check(disturb ? "R10 R6 R7 dout" : "R6 R7 dout", 32'(dout), 32'(e[AW]));
         check(down ? "R3 addr" : "R2 addr", 32'(mem_addr), 32'(e[AW-1:0]));
         if (disturb && k == 40) begin
            start    = 1'b1;
            mode_sel = down ? 3'b100 : 3'b110;
         end else if (disturb && k == 41) begin
            start    = 1'b0;
            mode_sel = 3'b011;
         end
         @(negedge clk);
      end
      cur_addr = expect_at(LOAD_K, down) >> 0;
      cur_addr = offs(down ? {AW{1'b1}} : '0, down, LN - 1);
   endtask

   task automatic run_ignored(input logic [2:0] mode);
      @(negedge clk);
      mode_sel = mode;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 6; k++) begin
         check("R4 busy", 32'(busy), 32'd0);
         check("R4 addr", 32'(mem_addr), 32'(cur_addr));
         @(negedge clk);
      end
   endtask

   task automatic check_reset_state(input string req);
      check({req, " busy"}, 32'(busy), 32'd0);
      check({req, " addr"}, 32'(mem_addr), 32'd0);
      check({req, " cclk"}, 32'(cclk), 32'd1);
      check({req, " rclk"}, 32'(rclk), 32'd0);
      check({req, " dout"}, 32'(dout), 32'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state, during and after reset
      repeat (3) @(negedge clk);
      check_reset_state("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("R1");

      // table walk over all eight mode codes
      for (int i = 0; i < 8; i++) begin
         if (VEC[i][1]) run_load(VEC[i][4:2], VEC[i][0], 1'b0);
         else           run_ignored(VEC[i][4:2]);
      end

      // R10: start and mode changes mid-load, both directions
      run_load(3'b110, 1'b1, 1'b1);
      run_load(3'b100, 1'b0, 1'b1);

      // back-to-back loads with opposite direction
      run_load(3'b110, 1'b1, 1'b0);
      run_ignored(3'b111);

      // R11: reset during a load
      @(negedge clk);
      mode_sel = 3'b110;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (50) @(negedge clk);
      check("R11 busy before reset", 32'(busy), 32'd1);
      rst_n = 1'b0;
      #1;
      check_reset_state("R11");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_reset_state("R11");
      cur_addr = '0;
      run_ignored(3'b000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule